// File: doc/BRIEF.md
# ADC Conversion Start Trigger Unit

This block sits in front of an analog-to-digital converter controller and decides the clock cycle in which a new conversion starts. It watches four start sources. Source 0 is an external pin with a selectable active edge. Source 1 is the end-of-conversion pulse of a partner converter. Source 2 is a sync pulse from a PWM unit. Source 3 is a match output of a subsystem timer. Each source has its own enable bit. Every source is brought into the converter clock domain and reduced to a one-cycle hit. The hits are merged into a single one-cycle start pulse, which is only issued while the converter is idle.

Sources 0 and 3 are sampled directly in the converter clock domain. Sources 1 and 2 are pulses in the subsystem clock domain. Each of these is converted to a toggle in that domain and then carried across into the converter domain. In the other direction, the converter's done pulse is carried back to the subsystem domain and comes out as a one-cycle `sync_out` pulse. Wiring one instance's `sync_out` to the other's partner input, in both directions, gives a ping-pong loop: a single external trigger then makes the two converters take turns until software clears the enables.

Top module: `adc_start_trigger`

## Requirements
- R1: `conv_start` is high for exactly one converter clock cycle per accepted trigger, and hits from several sources that land in the same cycle produce a single start.
- R2: Source 0 (`ext_start_pin`) triggers on a rising edge when `ext_fall_sel` is 0 and on a falling edge when it is 1; the opposite edge produces no start.
- R3: A one-cycle subsystem-clock pulse on `partner_sync_in`, with `src_enable[1]` set, produces exactly one start.
- R4: A one-cycle subsystem-clock pulse on `pwm_sync_in`, with `src_enable[2]` set, produces exactly one start.
- R5: A rising edge on `timer_match_in`, with `src_enable[3]` set, produces exactly one start; holding the level high produces no further starts.
- R6: A source whose `src_enable` bit is 0 (bit 0 = pin, 1 = partner, 2 = PWM, 3 = timer) never causes a start.
- R7: `conv_start` is only raised when `conv_busy` was low in the previous cycle; a trigger that arrives while the converter is busy is dropped and not replayed afterwards.
- R8: Every `conv_done` pulse produces exactly one `sync_out` pulse, one subsystem clock cycle wide.
- R9: With two instances cross-linked through `sync_out` and partner inputs, one external edge makes the two converters start strictly in turn, and clearing the enables stops the loop.
- R10: During and right after reset, `conv_start` and `sync_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_conv | input | 1 | Converter clock |
| rst_conv | input | 1 | Synchronous active-high reset, converter domain |
| clk_sys | input | 1 | Subsystem clock |
| rst_sys | input | 1 | Synchronous active-high reset, subsystem domain |
| src_enable | input | 4 | Per-source enable (bit 0 pin, 1 partner, 2 PWM, 3 timer) |
| ext_fall_sel | input | 1 | Source 0 edge: 0 rising, 1 falling |
| ext_start_pin | input | 1 | External start pin, asynchronous |
| partner_sync_in | input | 1 | Partner end-of-conversion pulse, subsystem domain |
| pwm_sync_in | input | 1 | PWM sync pulse, subsystem domain |
| timer_match_in | input | 1 | Subsystem timer match level |
| conv_busy | input | 1 | Converter is converting |
| conv_done | input | 1 | One-cycle end-of-conversion pulse, converter domain |
| conv_start | output | 1 | One-cycle conversion start, converter domain |
| sync_out | output | 1 | One-cycle end-of-conversion pulse, subsystem domain |

## Verification
The bench drives the pin through both edges under both polarity settings. A design that ignores `ext_fall_sel`, or that detects both edges, shows up as a start count of 1 where 0 is expected. A second PWM pulse is sent while a conversion is still in flight: a design that queues requests would start a second conversion once busy drops. Two simultaneous sources must yield one start, not two. In a ping-pong run between two linked instances, a broken clock crossing either stalls the loop or makes one side start twice in a row, and starts that continue after the enables are cleared expose a missing mask.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    localparam int NUM_SRC = 4;
    localparam int SYS_SRC = 2;

    typedef logic [NUM_SRC-1:0] trig_mask_t;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_e;

    // Bit order follows the enable mask: ext is bit 0, timer is bit 3.
    typedef struct packed {
        logic timer;
        logic pwm;
        logic partner;
        logic ext;
    } trig_vec_t;

    function automatic logic edge_hit(input logic cur, input logic prev, input edge_sel_e sel);
        return (sel == EDGE_FALL) ? (prev & ~cur) : (cur & ~prev);
    endfunction

    function automatic logic any_armed(input trig_vec_t hits, input trig_mask_t en);
        return |(trig_mask_t'(hits) & en);
    endfunction

endpackage

// File: rtl/trig_sync_bit.sv
module trig_sync_bit #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/trig_edge_det.sv
module trig_edge_det
    import adc_trig_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      level,
    input  edge_sel_e sel,
    output logic      hit
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= level;
    end

    assign hit = edge_hit(level, prev, sel);
endmodule

// File: rtl/trig_toggle_xfer.sv
module trig_toggle_xfer #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst,
    output logic dst_pulse
);
    logic tgl_src;
    logic tgl_dst;
    logic tgl_prev;
    logic pulse_q;

    always_ff @(posedge src_clk) begin
        if (src_rst)        tgl_src <= 1'b0;
        else if (src_pulse) tgl_src <= ~tgl_src;
    end

    trig_sync_bit #(.STAGES(STAGES)) u_sync (
        .clk (dst_clk),
        .rst (dst_rst),
        .d   (tgl_src),
        .q   (tgl_dst)
    );

    always_ff @(posedge dst_clk) begin
        if (dst_rst) begin
            tgl_prev <= 1'b0;
            pulse_q  <= 1'b0;
        end else begin
            tgl_prev <= tgl_dst;
            pulse_q  <= tgl_dst ^ tgl_prev;
        end
    end

    assign dst_pulse = pulse_q;
endmodule

// File: rtl/adc_start_trigger.sv
module adc_start_trigger
    import adc_trig_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_conv,
    input  logic               rst_conv,
    input  logic               clk_sys,
    input  logic               rst_sys,
    input  logic [NUM_SRC-1:0] src_enable,
    input  logic               ext_fall_sel,
    input  logic               ext_start_pin,
    input  logic               partner_sync_in,
    input  logic               pwm_sync_in,
    input  logic               timer_match_in,
    input  logic               conv_busy,
    input  logic               conv_done,
    output logic               conv_start,
    output logic               sync_out
);
    trig_vec_t          hits;
    logic               ext_lvl, tmr_lvl;
    logic               ext_hit, tmr_hit;
    logic [SYS_SRC-1:0] sys_in, sys_hit;
    logic               armed;
    logic               start_q;

    // Converter-domain sources: pin (polarity selectable) and timer match.
    trig_sync_bit #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk(clk_conv), .rst(rst_conv), .d(ext_start_pin), .q(ext_lvl)
    );
    trig_edge_det u_ext_edge (
        .clk(clk_conv), .rst(rst_conv), .level(ext_lvl),
        .sel(edge_sel_e'(ext_fall_sel)), .hit(ext_hit)
    );

    trig_sync_bit #(.STAGES(SYNC_STAGES)) u_tmr_sync (
        .clk(clk_conv), .rst(rst_conv), .d(timer_match_in), .q(tmr_lvl)
    );
    trig_edge_det u_tmr_edge (
        .clk(clk_conv), .rst(rst_conv), .level(tmr_lvl),
        .sel(EDGE_RISE), .hit(tmr_hit)
    );

    // Subsystem-domain sources: captured as toggles, carried to the converter clock.
    assign sys_in = {pwm_sync_in, partner_sync_in};

    generate
        for (genvar k = 0; k < SYS_SRC; k++) begin : g_sys_src
            trig_toggle_xfer #(.STAGES(SYNC_STAGES)) u_xfer (
                .src_clk   (clk_sys),
                .src_rst   (rst_sys),
                .src_pulse (sys_in[k]),
                .dst_clk   (clk_conv),
                .dst_rst   (rst_conv),
                .dst_pulse (sys_hit[k])
            );
        end
    endgenerate

    always_comb begin
        hits.ext     = ext_hit;
        hits.partner = sys_hit[0];
        hits.pwm     = sys_hit[1];
        hits.timer   = tmr_hit;
        armed        = any_armed(hits, src_enable);
    end

    // One start per accepted hit; hits during busy or right after a start are dropped.
    always_ff @(posedge clk_conv) begin
        if (rst_conv) start_q <= 1'b0;
        else          start_q <= armed & ~conv_busy & ~start_q;
    end

    assign conv_start = start_q;

    // End of conversion back to the subsystem domain for chaining.
    trig_toggle_xfer #(.STAGES(SYNC_STAGES)) u_done_xfer (
        .src_clk   (clk_conv),
        .src_rst   (rst_conv),
        .src_pulse (conv_done),
        .dst_clk   (clk_sys),
        .dst_rst   (rst_sys),
        .dst_pulse (sync_out)
    );
endmodule

// File: rtl/adc_start_trigger_chk.sv
module adc_start_trigger_chk (
    input logic       clk_conv,
    input logic       rst_conv,
    input logic       clk_sys,
    input logic       rst_sys,
    input logic [3:0] src_enable,
    input logic       conv_busy,
    input logic       conv_start,
    input logic       sync_out
);
    assert_start_single_R1: assert property (@(posedge clk_conv) disable iff (rst_conv)
        conv_start |=> !conv_start);

    assert_masked_R6: assert property (@(posedge clk_conv) disable iff (rst_conv)
        ($past(src_enable) == 4'b0000) |-> !conv_start);

    assert_start_idle_R7: assert property (@(posedge clk_conv) disable iff (rst_conv)
        conv_start |-> !$past(conv_busy));

    assert_sync_single_R8: assert property (@(posedge clk_sys) disable iff (rst_sys)
        sync_out |=> !sync_out);

    assert_reset_start_R10: assert property (@(posedge clk_conv)
        rst_conv |=> !conv_start);

    assert_reset_sync_R10: assert property (@(posedge clk_sys)
        rst_sys |=> !sync_out);
endmodule

bind adc_start_trigger adc_start_trigger_chk u_chk (
    .clk_conv   (clk_conv),
    .rst_conv   (rst_conv),
    .clk_sys    (clk_sys),
    .rst_sys    (rst_sys),
    .src_enable (src_enable),
    .conv_busy  (conv_busy),
    .conv_start (conv_start),
    .sync_out   (sync_out)
);

// File: tb/adc_start_trigger_test.sv
module adc_start_trigger_test;
    localparam int BUSY_LEN = 12;
    localparam int WIN      = 40;
    localparam int NVEC     = 11;
    // [11:8] enable, [7] fall select, [6:4] stimulus (0 pin, 1 partner, 2 pwm, 3 timer),
    // [3:2] starts expected after stimulus (pin: after first edge), [1:0] pin: after return edge
    localparam logic [11:0] VEC [NVEC] = '{
        12'b0001_0_000_01_00,
        12'b0001_1_000_00_01,
        12'b0000_0_000_00_00,
        12'b1110_0_000_00_00,
        12'b0010_0_001_01_00,
        12'b1101_0_001_00_00,
        12'b0100_0_010_01_00,
        12'b1011_0_010_00_00,
        12'b1000_0_011_01_00,
        12'b0111_0_011_00_00,
        12'b1111_0_011_01_00
    };

    logic clk_conv = 1'b0, clk_sys = 1'b0;
    always #5 clk_conv = ~clk_conv;   // 100 MHz
    always #4 clk_sys  = ~clk_sys;

    logic rst_conv = 1'b1, rst_sys = 1'b1;
    logic [3:0] en_a = 4'b0, en_b = 4'b0;
    logic fall_a = 1'b0, pin_a = 1'b0, pin_b = 1'b0;
    logic inj_partner = 1'b0, pwm_pulse = 1'b0, tmr_lvl = 1'b0;
    logic start_a, start_b, sync_a, sync_b;
    logic busy_a, busy_b, done_a, done_b;

    adc_start_trigger uut (
        .clk_conv(clk_conv), .rst_conv(rst_conv), .clk_sys(clk_sys), .rst_sys(rst_sys),
        .src_enable(en_a), .ext_fall_sel(fall_a), .ext_start_pin(pin_a),
        .partner_sync_in(inj_partner | sync_b), .pwm_sync_in(pwm_pulse),
        .timer_match_in(tmr_lvl), .conv_busy(busy_a), .conv_done(done_a),
        .conv_start(start_a), .sync_out(sync_a)
    );

    adc_start_trigger uut_peer (
        .clk_conv(clk_conv), .rst_conv(rst_conv), .clk_sys(clk_sys), .rst_sys(rst_sys),
        .src_enable(en_b), .ext_fall_sel(1'b0), .ext_start_pin(pin_b),
        .partner_sync_in(sync_a), .pwm_sync_in(1'b0),
        .timer_match_in(1'b0), .conv_busy(busy_b), .conv_done(done_b),
        .conv_start(start_b), .sync_out(sync_b)
    );

    // Converter stand-ins
    int cnt_a = 0, cnt_b = 0;
    always @(posedge clk_conv) begin
        if (rst_conv) begin
            busy_a <= 1'b0; done_a <= 1'b0; cnt_a <= 0;
            busy_b <= 1'b0; done_b <= 1'b0; cnt_b <= 0;
        end else begin
            done_a <= 1'b0;
            done_b <= 1'b0;
            if (start_a && !busy_a) begin busy_a <= 1'b1; cnt_a <= BUSY_LEN; end
            else if (busy_a) begin
                if (cnt_a == 1) begin busy_a <= 1'b0; done_a <= 1'b1; end
                else cnt_a <= cnt_a - 1;
            end
            if (start_b && !busy_b) begin busy_b <= 1'b1; cnt_b <= BUSY_LEN; end
            else if (busy_b) begin
                if (cnt_b == 1) begin busy_b <= 1'b0; done_b <= 1'b1; end
                else cnt_b <= cnt_b - 1;
            end
        end
    end

    // Event counters
    int n_start_a = 0, n_start_b = 0, n_done_a = 0, n_sync_a = 0, alt_err = 0, last_who = -1;
    logic pp_on = 1'b0;
    always @(posedge clk_conv) begin
        if (start_a) n_start_a <= n_start_a + 1;
        if (start_b) n_start_b <= n_start_b + 1;
        if (done_a)  n_done_a  <= n_done_a + 1;
        if (!pp_on) last_who <= -1;
        else if (start_a && start_b) alt_err <= alt_err + 1;
        else if (start_a) begin
            if (last_who == 0) alt_err <= alt_err + 1;
            last_who <= 0;
        end else if (start_b) begin
            if (last_who == 1) alt_err <= alt_err + 1;
            last_who <= 1;
        end
    end
    always @(posedge clk_sys) if (sync_a) n_sync_a <= n_sync_a + 1;

    int n_checks = 0, n_err = 0;
    logic finished = 1'b0;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic conv_cycles(input int n);
        repeat (n) @(negedge clk_conv);
    endtask

    task automatic sys_cycles(input int n);
        repeat (n) @(negedge clk_sys);
    endtask

    task automatic pulse_pwm();
        @(negedge clk_sys); pwm_pulse = 1'b1;
        @(negedge clk_sys); pwm_pulse = 1'b0;
    endtask

    task automatic pulse_partner();
        @(negedge clk_sys); inj_partner = 1'b1;
        @(negedge clk_sys); inj_partner = 1'b0;
    endtask

    task automatic pulse_timer();
        @(negedge clk_sys); tmr_lvl = 1'b1;
        sys_cycles(4);
        tmr_lvl = 1'b0;
    endtask

    function automatic string tag_for(input logic [3:0] en, input int src);
        if (!en[src]) return "R6 disabled source";
        case (src)
            0: return "R2 pin edge";
            1: return "R3 partner sync";
            2: return "R4 pwm sync";
            default: return "R5 timer match";
        endcase
    endfunction

    initial begin
        #1000000;
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        int base;
        int da, db;
        // R10: reset state
        conv_cycles(3);
        check("R10 start in reset", int'(start_a), 0);
        check("R10 sync_out in reset", int'(sync_a), 0);
        conv_cycles(7);
        rst_conv = 1'b0;
        rst_sys  = 1'b0;
        conv_cycles(5);
        check("R10 start after reset", n_start_a, 0);
        check("R10 sync_out after reset", n_sync_a, 0);

        // Table walk: one source at a time on instance uut
        for (int i = 0; i < NVEC; i++) begin
            logic [11:0] v;
            int src;
            v      = VEC[i];
            en_a   = v[11:8];
            fall_a = v[7];
            src    = int'(v[6:4]);
            conv_cycles(5);
            base = n_start_a;
            case (src)
                0: begin
                    pin_a = 1'b1;
                    conv_cycles(WIN);
                    check(tag_for(v[11:8], 0), n_start_a - base, int'(v[3:2]));
                    base = n_start_a;
                    pin_a = 1'b0;
                    conv_cycles(WIN);
                    check(tag_for(v[11:8], 0), n_start_a - base, int'(v[1:0]));
                end
                1: begin pulse_partner(); conv_cycles(WIN); check(tag_for(v[11:8], 1), n_start_a - base, int'(v[3:2])); end
                2: begin pulse_pwm();     conv_cycles(WIN); check(tag_for(v[11:8], 2), n_start_a - base, int'(v[3:2])); end
                default: begin pulse_timer(); conv_cycles(WIN); check(tag_for(v[11:8], 3), n_start_a - base, int'(v[3:2])); end
            endcase
        end

        // R7: second request during busy is dropped, not replayed
        en_a = 4'b0100;
        conv_cycles(5);
        base = n_start_a;
        pulse_pwm();
        sys_cycles(8);
        pulse_pwm();
        conv_cycles(WIN);
        check("R7 request while busy", n_start_a - base, 1);

        // R1: two sources in the same cycle give one start
        en_a = 4'b1111;
        conv_cycles(5);
        base = n_start_a;
        @(negedge clk_sys); pwm_pulse = 1'b1; inj_partner = 1'b1;
        @(negedge clk_sys); pwm_pulse = 1'b0; inj_partner = 1'b0;
        conv_cycles(WIN);
        check("R1 merged sources", n_start_a - base, 1);

        // R8: one sync_out per done
        check("R8 sync_out per done", n_sync_a, n_done_a);
        check("R8 done count", n_done_a, n_start_a);

        // R9: ping-pong between the two instances
        en_a   = 4'b0011;
        fall_a = 1'b0;
        en_b   = 4'b0010;
        pp_on  = 1'b1;
        conv_cycles(5);
        base = n_start_a;
        db   = n_start_b;
        pin_a = 1'b1;
        conv_cycles(400);
        da = n_start_a - base;
        db = n_start_b - db;
        check("R9 ping-pong uut runs", int'(da >= 5), 1);
        check("R9 ping-pong peer runs", int'(db >= 5), 1);
        check("R9 ping-pong balance", int'(da - db <= 1 && db - da <= 1), 1);
        check("R9 strict alternation", alt_err, 0);
        en_a = 4'b0000;
        en_b = 4'b0000;
        conv_cycles(60);
        base = n_start_a;
        db   = n_start_b;
        conv_cycles(200);
        check("R9 stop uut", n_start_a - base, 0);
        check("R9 stop peer", n_start_b - db, 0);
        pp_on = 1'b0;
        pin_a = 1'b0;

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule